// File: doc/BRIEF.md
# Shared-PLL Divider Output Gating Controller

This block controls the outputs of a group of fractional-divider clocks that all take their clock from one PLL. Its inputs come from a single register clock domain: the lock status of the PLL, one bypass bit and one enable bit for the whole group, and one software gate bit for each divider. For every divider it drives three registered outputs: a clock enable, a source select, and a sticky flag. The source select picks the reference clock or the divided PLL clock. The sticky flag marks a divider that has not yet been through a gate/ungate cycle since the PLL last locked.

When the group is not bypassed and the PLL loses lock, the block disables the PLL output and gates every divider without any software action. When lock returns, the block releases the gating. That automatic gate-then-ungate cycle counts as a divider reset. An unlock while the group is bypassed gates nothing. In that case a divider that relocks without having been gated is flagged, and the flag stays set until software pulses that divider's gate bit. The analog PLL, the fractional arithmetic and the clock cells are modelled only as the enable and select signals.

Top module: `pfd_gate_ctrl`

## Requirements
- R1: After reset the outputs are: every clock enable 1, every source select 1 (reference clock), every reset-pending flag 1, and PLL output enable 1.
- R2: Every output is registered and reflects the inputs sampled at the previous rising clock edge. Each source select equals the sampled group bypass bit: 1 selects the reference clock, 0 selects the divided PLL clock.
- R3: While the sampled group enable is 0, every clock enable and the PLL output enable are 0, whatever the gate bits and the bypass bit say.
- R4: A divider's gate bit at 1 clears only that divider's clock enable. Bit i of the gate vector controls divider i.
- R5: A divider that is both bypassed and gated has its clock enable at 0.
- R6: With bypass clear and the PLL unlocked, every clock enable and the PLL output enable are 0. Once lock is back, they follow the gate bits and the enable bit again.
- R7: With bypass set, an unlocked PLL gates nothing. The clock enables and the PLL output enable depend only on the gate bits and the enable bit.
- R8: At a rise of the lock input, a divider that was gated while the PLL was unlocked has its reset-pending flag cleared. Gating here means a software gate, automatic gating or group enable at 0.
- R9: At a rise of the lock input, a divider that was not gated during the unlocked period has its reset-pending flag set. The flag stays set across later cycles.
- R10: A divider's reset-pending flag clears in the cycle after its gate bit is sampled at 1 and then at 0. The flags of the other dividers are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pll_lock | input | 1 | PLL lock status |
| grp_bypass | input | 1 | Group bypass: dividers output the reference clock |
| grp_enable | input | 1 | Group enable: 0 disables every divider output |
| sw_gate | input | N_DIV | Per-divider software gate bits |
| pll_out_en | output | 1 | PLL output enable |
| div_clk_en | output | N_DIV | Per-divider clock enable |
| div_src_ref | output | N_DIV | Per-divider source select, 1 = reference clock |
| div_rst_pend | output | N_DIV | Per-divider sticky reset-pending flag |

## Verification
A wrong record of gating during an unlocked period does not show at once. It shows only at the next rise of the lock input, when a reset-pending flag comes out inverted one cycle later. The bench therefore covers relock after automatic gating, relock while bypassed, and relock while software gating is held. A bad group-gating term shows in the cycle right after the input changes, as a clock enable or PLL output enable of the wrong value. Every check samples one cycle after the stimulus, so an extra or missing register stage also fails.

// File: rtl/pfd_gate_pkg.sv
package pfd_gate_pkg;

  localparam int unsigned DEF_N_DIV = 4;

  typedef struct packed {
    logic bypass;
    logic enable;
    logic auto_gate;
    logic lock_rise;
    logic unlocked;
  } grp_ctrl_t;

endpackage

// File: rtl/pfd_rst_sync.sv
module pfd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pfd_lock_track.sv
module pfd_lock_track
  import pfd_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      pll_lock,
  input  logic      grp_bypass,
  input  logic      grp_enable,
  output grp_ctrl_t grp_ctrl,
  output logic      pll_out_en
);

  logic lock_q, lock_d;
  logic pll_en_q, pll_en_d;
  logic auto_gate;

  always_comb begin
    auto_gate = ~grp_bypass & ~pll_lock;
    lock_d    = pll_lock;
    pll_en_d  = grp_enable & ~auto_gate;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q   <= 1'b0;
      pll_en_q <= 1'b1;
    end else begin
      lock_q   <= lock_d;
      pll_en_q <= pll_en_d;
    end
  end

  always_comb begin
    grp_ctrl.bypass    = grp_bypass;
    grp_ctrl.enable    = grp_enable;
    grp_ctrl.auto_gate = auto_gate;
    grp_ctrl.lock_rise = pll_lock & ~lock_q;
    grp_ctrl.unlocked  = ~pll_lock;
  end

  assign pll_out_en = pll_en_q;

  // R6: unlocked without bypass forces the PLL output off next cycle
  p_auto_gate_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(!grp_bypass && !pll_lock)) |-> !pll_out_en);

  // R3: group disable turns PLL output off
  p_enable_off_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!$past(grp_enable)) |-> !pll_out_en);

endmodule

// File: rtl/pfd_div_lane.sv
module pfd_div_lane
  import pfd_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  grp_ctrl_t grp_ctrl,
  input  logic      gate_in,
  output logic      clk_en,
  output logic      src_ref,
  output logic      rst_pend
);

  logic en_q, en_d;
  logic sel_q, sel_d;
  logic pend_q, pend_d;
  logic gate_q, gate_d;
  logic seen_q, seen_d;
  logic gated_now, gate_fall;

  always_comb begin
    gated_now = gate_in | grp_ctrl.auto_gate | ~grp_ctrl.enable;
    gate_fall = gate_q & ~gate_in;
    en_d      = ~gated_now;
    sel_d     = grp_ctrl.bypass;
    gate_d    = gate_in;

    seen_d = seen_q;
    if (grp_ctrl.lock_rise)                  seen_d = 1'b0;
    else if (grp_ctrl.unlocked && gated_now) seen_d = 1'b1;

    pend_d = pend_q;
    if (grp_ctrl.lock_rise) pend_d = ~seen_q;
    else if (gate_fall)     pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b1;
      sel_q  <= 1'b1;
      pend_q <= 1'b1;
      gate_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      sel_q  <= sel_d;
      pend_q <= pend_d;
      gate_q <= gate_d;
      seen_q <= seen_d;
    end
  end

  assign clk_en   = en_q;
  assign src_ref  = sel_q;
  assign rst_pend = pend_q;

  // R7: bypassed unlock with no software gating keeps the divider running
  p_bypass_unlock_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(grp_ctrl.bypass && grp_ctrl.unlocked && grp_ctrl.enable && !gate_in))
    |-> clk_en);

  // R2: source select tracks sampled bypass
  p_sel_follow_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    src_ref == $past(grp_ctrl.bypass));

  // R10: gate high then low clears the pending flag
  p_pend_clear_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(gate_q && !gate_in && !grp_ctrl.lock_rise)) |-> !rst_pend);

  // R5: gated divider never enabled, bypassed or not
  p_gated_off_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(gate_in) |-> !clk_en);

endmodule

// File: rtl/pfd_gate_ctrl.sv
module pfd_gate_ctrl
  import pfd_gate_pkg::*;
#(
  parameter int unsigned N_DIV       = DEF_N_DIV,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_lock,
  input  logic             grp_bypass,
  input  logic             grp_enable,
  input  logic [N_DIV-1:0] sw_gate,
  output logic             pll_out_en,
  output logic [N_DIV-1:0] div_clk_en,
  output logic [N_DIV-1:0] div_src_ref,
  output logic [N_DIV-1:0] div_rst_pend
);

  logic      rst_ni;
  grp_ctrl_t grp_ctrl;

  pfd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  pfd_lock_track u_lock (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .pll_lock   (pll_lock),
    .grp_bypass (grp_bypass),
    .grp_enable (grp_enable),
    .grp_ctrl   (grp_ctrl),
    .pll_out_en (pll_out_en)
  );

  for (genvar gi = 0; gi < N_DIV; gi++) begin : g_lane
    pfd_div_lane u_lane (
      .clk      (clk),
      .rst_ni   (rst_ni),
      .grp_ctrl (grp_ctrl),
      .gate_in  (sw_gate[gi]),
      .clk_en   (div_clk_en[gi]),
      .src_ref  (div_src_ref[gi]),
      .rst_pend (div_rst_pend[gi])
    );
  end

  // R3: group disable turns off every divider
  p_grp_off_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!$past(grp_enable)) |-> (div_clk_en == '0));

  // R6: automatic gating of all dividers
  p_auto_all_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(!grp_bypass && !pll_lock)) |-> (div_clk_en == '0));

endmodule

// File: tb/tb_pfd_gate_ctrl.sv
module tb_pfd_gate_ctrl;

  localparam int    N       = 4;
  localparam time   CLK_PER = 10ns;
  localparam int    WD_MAX  = 5000;

  typedef struct packed {
    logic [N-1:0] en;
    logic [N-1:0] sel;
    logic [N-1:0] pend;
    logic         pll;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pll_lock, grp_bypass, grp_enable;
  logic [N-1:0] sw_gate;
  logic         pll_out_en;
  logic [N-1:0] div_clk_en, div_src_ref, div_rst_pend;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #(CLK_PER/2) clk = ~clk;

  pfd_gate_ctrl #(.N_DIV(N)) dut (
    .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .grp_bypass(grp_bypass),
    .grp_enable(grp_enable), .sw_gate(sw_gate), .pll_out_en(pll_out_en),
    .div_clk_en(div_clk_en), .div_src_ref(div_src_ref), .div_rst_pend(div_rst_pend)
  );

  // driver: apply inputs at negedge, queue the result expected after the next edge
  task automatic step(input logic lk, input logic byp, input logic en,
                      input logic [N-1:0] g, input exp_t e, input string tag);
    @(negedge clk);
    pll_lock = lk; grp_bypass = byp; grp_enable = en; sw_gate = g;
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compare at the negedge after the capturing edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      exp_t  a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = '{en: div_clk_en, sel: div_src_ref, pend: div_rst_pend, pll: pll_out_en};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual en=%b sel=%b pend=%b pll=%b expected en=%b sel=%b pend=%b pll=%b",
                 t, a.en, a.sel, a.pend, a.pll, e.en, e.sel, e.pend, e.pll);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_MAX) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pll_lock = 1'b0; grp_bypass = 1'b1; grp_enable = 1'b1; sw_gate = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state; R7 bypassed unlock gates nothing
    step(0, 1, 1, 4'h0, '{en:4'hF, sel:4'hF, pend:4'hF, pll:1'b1}, "R1 reset state / R7");
    // R9 relock without gating keeps flags set
    step(1, 1, 1, 4'h0, '{en:4'hF, sel:4'hF, pend:4'hF, pll:1'b1}, "R9 relock no gate");
    // R4 R5 bypassed and gated divider 0
    step(1, 1, 1, 4'h1, '{en:4'hE, sel:4'hF, pend:4'hF, pll:1'b1}, "R4 R5 gate div0 bypassed");
    // R10 release clears divider 0 flag only
    step(1, 1, 1, 4'h0, '{en:4'hF, sel:4'hF, pend:4'hE, pll:1'b1}, "R10 pulse div0");
    // R2 bypass removed selects PLL clock
    step(1, 0, 1, 4'h0, '{en:4'hF, sel:4'h0, pend:4'hE, pll:1'b1}, "R2 bypass clear");
    step(1, 0, 1, 4'h2, '{en:4'hD, sel:4'h0, pend:4'hE, pll:1'b1}, "R4 gate div1");
    step(1, 0, 1, 4'h0, '{en:4'hF, sel:4'h0, pend:4'hC, pll:1'b1}, "R10 pulse div1");
    // R3 disable overrides gate bits
    step(1, 0, 0, 4'h4, '{en:4'h0, sel:4'h0, pend:4'hC, pll:1'b0}, "R3 group disable");
    step(1, 0, 1, 4'h0, '{en:4'hF, sel:4'h0, pend:4'h8, pll:1'b1}, "R3 R10 reenable, div2 pulse");
    // R6 automatic gating on unlock
    step(0, 0, 1, 4'h0, '{en:4'h0, sel:4'h0, pend:4'h8, pll:1'b0}, "R6 unlock auto gate");
    step(0, 0, 1, 4'h0, '{en:4'h0, sel:4'h0, pend:4'h8, pll:1'b0}, "R6 stays gated");
    // R8 relock after auto gate clears every flag
    step(1, 0, 1, 4'h0, '{en:4'hF, sel:4'h0, pend:4'h0, pll:1'b1}, "R8 relock after auto gate");
    // R7 bypassed unlock: no gating
    step(0, 1, 1, 4'h0, '{en:4'hF, sel:4'hF, pend:4'h0, pll:1'b1}, "R7 bypassed unlock");
    // R9 relock without gating sets flags
    step(1, 1, 1, 4'h0, '{en:4'hF, sel:4'hF, pend:4'hF, pll:1'b1}, "R9 relock sets flags");
    step(1, 1, 1, 4'h0, '{en:4'hF, sel:4'hF, pend:4'hF, pll:1'b1}, "R9 flags sticky");
    step(1, 1, 1, 4'hF, '{en:4'h0, sel:4'hF, pend:4'hF, pll:1'b1}, "R5 all gated bypassed");
    step(0, 1, 1, 4'hF, '{en:4'h0, sel:4'hF, pend:4'hF, pll:1'b1}, "R7 software gate during unlock");
    // R8 software gating during unlock counts
    step(1, 1, 1, 4'hF, '{en:4'h0, sel:4'hF, pend:4'h0, pll:1'b1}, "R8 relock after sw gate");
    step(1, 1, 1, 4'h0, '{en:4'hF, sel:4'hF, pend:4'h0, pll:1'b1}, "R4 release all");
    step(1, 1, 0, 4'h0, '{en:4'h0, sel:4'hF, pend:4'h0, pll:1'b0}, "R3 disable while bypassed");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule